// File: doc/BRIEF.md
# Universal Shift/Rotate Register

This block is a small clocked register whose next content is picked each cycle by a three-bit function code. Depending on the code it takes a fresh parallel word, moves its bits one place toward the low or the high end with a zero entering the vacated end, moves them one place end-around, or fills every bit with one. An enable input selects whether the register acts at all on a given edge. With the enable low it keeps its value, so several such registers can share one set of function and data lines and only the selected one changes.

An active-high asynchronous reset clears the register at once, independent of the clock. All other changes happen on the rising clock edge. The width is a parameter with a default of four bits. The function codes below are written for that width, and the same moves apply at any width of two or more.

Top module: `uniShiftReg`

## Requirements
- R1: While `reset` is 1, `q` is all zeros. This takes effect as soon as `reset` rises, without waiting for a clock edge.
- R2: With `enable` = 1 and `func` = 3'b000 or 3'b001, the rising edge loads `q <= par`.
- R3: With `enable` = 1 and `func` = 3'b010, the rising edge shifts toward bit 0 with a zero entering the top bit. For 4 bits, {q3,q2,q1,q0} becomes {0,q3,q2,q1}.
- R4: With `enable` = 1 and `func` = 3'b011, the rising edge rotates toward bit 0. For 4 bits, the result is {q0,q3,q2,q1}.
- R5: With `enable` = 1 and `func` = 3'b100, the rising edge shifts toward the top bit with a zero entering bit 0. For 4 bits, the result is {q2,q1,q0,0}.
- R6: With `enable` = 1 and `func` = 3'b101, the rising edge rotates toward the top bit. For 4 bits, the result is {q2,q1,q0,q3}.
- R7: With `enable` = 1 and `func` = 3'b110 or 3'b111, the rising edge sets every bit of `q` to 1.
- R8: With `enable` = 0, `q` is unchanged across a rising edge for every value of `func` and `par`.
- R9: Reset takes priority over any function code that is present at an edge while reset is held. The first rising edge after `reset` falls applies the function code present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| reset | input | 1 | Asynchronous clear, active high |
| enable | input | 1 | Gates every function; 0 holds the register |
| func | input | 3 | Function select code |
| par | input | WIDTH | Parallel load data |
| q | output | WIDTH | Register contents |

## Verification
Two functions of this block can meet in the same cycle: the asynchronous clear and a clocked function such as fill-with-ones or a load. The bench provokes this by raising `reset` between clock edges. It first checks that `q` is already zero before the next edge arrives. It then holds reset across edges while an enabled fill code is driven, and expects zeros to win. After reset is released, the bench expects the very next edge to apply the code driven at that edge. A model kept in the bench also follows long random runs of codes, data and enable and compares against `q` after every edge.

// File: rtl/uniShiftPkg.sv
package uniShiftPkg;

  // Function select codes (a trailing x means don't-care)
  localparam logic [2:0] FN_SHR  = 3'b010;
  localparam logic [2:0] FN_ROTR = 3'b011;
  localparam logic [2:0] FN_SHL  = 3'b100;
  localparam logic [2:0] FN_ROTL = 3'b101;

  // One strobe per datapath action; exactly one is set each cycle
  typedef struct packed {
    logic load;
    logic shiftDn;
    logic rotDn;
    logic shiftUp;
    logic rotUp;
    logic fill;
    logic hold;
  } stepCtl_t;

endpackage

// File: rtl/uniShiftCtrl.sv
module uniShiftCtrl
  import uniShiftPkg::*;
(
  input  logic       enable,
  input  logic [2:0] func,
  output stepCtl_t   stp
);

  always_comb begin
    stp = '0;
    if (!enable) begin
      stp.hold = 1'b1;
    end else begin
      casez (func)
        3'b00?:  stp.load    = 1'b1;
        FN_SHR:  stp.shiftDn = 1'b1;
        FN_ROTR: stp.rotDn   = 1'b1;
        FN_SHL:  stp.shiftUp = 1'b1;
        FN_ROTL: stp.rotUp   = 1'b1;
        3'b11?:  stp.fill    = 1'b1;
        default: stp.hold    = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/uniShiftPath.sv
module uniShiftPath
  import uniShiftPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             reset,
  input  stepCtl_t         stp,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] qOut
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] qReg;
  logic [WIDTH-1:0] nextQ;

  logic moveDn;
  logic moveUp;
  assign moveDn = stp.shiftDn | stp.rotDn;
  assign moveUp = stp.shiftUp | stp.rotUp;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromLow;
    logic fromHigh;
    if (i == 0) begin : g_low_end
      assign fromLow = stp.rotUp & qReg[TOP];
    end else begin : g_low_mid
      assign fromLow = qReg[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign fromHigh = stp.rotDn & qReg[0];
    end else begin : g_high_mid
      assign fromHigh = qReg[i+1];
    end
    assign nextQ[i] = (stp.load & par[i])
                    | (moveDn & fromHigh)
                    | (moveUp & fromLow)
                    | stp.fill
                    | (stp.hold & qReg[i]);
  end

  always_ff @(posedge clk or posedge reset) begin
    if (reset) qReg <= '0;
    else       qReg <= nextQ;
  end

  assign qOut = qReg;

  // R8: the hold strobe from control leaves the stored word untouched
  p_hold_strobe_r8: assert property (@(posedge clk) disable iff (reset)
    stp.hold |=> qReg == $past(qReg));

endmodule

// File: rtl/uniShiftReg.sv
module uniShiftReg
  import uniShiftPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             enable,
  input  logic [2:0]       func,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  stepCtl_t stp;

  uniShiftCtrl u_ctrl (
    .enable (enable),
    .func   (func),
    .stp    (stp)
  );

  uniShiftPath #(.WIDTH(WIDTH)) u_path (
    .clk   (clk),
    .reset (reset),
    .stp   (stp),
    .par   (par),
    .qOut  (q)
  );

  p_reset_r1: assert property (@(posedge clk)
    reset |-> q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (reset)
    (enable && func[2:1] == 2'b00) |=> q == $past(par));

  p_shr_r3: assert property (@(posedge clk) disable iff (reset)
    (enable && func == 3'b010) |=> q == {1'b0, $past(q[TOP:1])});

  p_rotr_r4: assert property (@(posedge clk) disable iff (reset)
    (enable && func == 3'b011) |=> q == {$past(q[0]), $past(q[TOP:1])});

  p_shl_r5: assert property (@(posedge clk) disable iff (reset)
    (enable && func == 3'b100) |=> q == {$past(q[TOP-1:0]), 1'b0});

  p_rotl_r6: assert property (@(posedge clk) disable iff (reset)
    (enable && func == 3'b101) |=> q == {$past(q[TOP-1:0]), $past(q[TOP])});

  p_ones_r7: assert property (@(posedge clk) disable iff (reset)
    (enable && func[2:1] == 2'b11) |=> q == '1);

  p_hold_r8: assert property (@(posedge clk) disable iff (reset)
    !enable |=> q == $past(q));

endmodule

// File: tb/sim_uniShiftReg.sv
module sim_uniShiftReg;

  logic       clk = 1'b0;
  logic       reset;
  logic       enable;
  logic [2:0] func;
  logic [3:0] par;
  logic [3:0] q;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl;

  always #10 clk = ~clk;

  uniShiftReg #(.WIDTH(4)) u0 (
    .clk(clk), .reset(reset), .enable(enable),
    .func(func), .par(par), .q(q)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [3:0] cur, input logic [2:0] f,
                                       input logic [3:0] d, input logic en);
    if (!en) return cur;
    casez (f)
      3'b00?: return d;
      3'b010: return {1'b0, cur[3:1]};
      3'b011: return {cur[0], cur[3:1]};
      3'b100: return {cur[2:0], 1'b0};
      3'b101: return {cur[2:0], cur[3]};
      default: return 4'b1111;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] f, input logic en);
    if (!en) return "R8";
    casez (f)
      3'b00?: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One edge with given inputs, then compare with the model
  task automatic step(input logic [2:0] f, input logic [3:0] d, input logic en, input string tag);
    @(negedge clk);
    func = f; par = d; enable = en;
    @(posedge clk);
    #2;
    mdl = model(mdl, f, d, en);
    chk(tag, q, mdl);
  endtask

  task automatic t_reset_state;
    chk("R1 initial", q, 4'b0000);
    @(negedge clk);
    reset = 1'b0;
    mdl = 4'b0000;
  endtask

  task automatic t_load;
    step(3'b000, 4'b1011, 1'b1, "R2 code000");
    step(3'b001, 4'b0110, 1'b1, "R2 code001");
  endtask

  task automatic t_shift_right;
    step(3'b000, 4'b1101, 1'b1, "R2 preload");
    step(3'b010, 4'b0000, 1'b1, "R3 shr 1101");
    step(3'b010, 4'b1111, 1'b1, "R3 shr 0110");
  endtask

  task automatic t_rotate_right;
    step(3'b000, 4'b1001, 1'b1, "R2 preload");
    step(3'b011, 4'b0000, 1'b1, "R4 rotr 1001");
    step(3'b011, 4'b0000, 1'b1, "R4 rotr 1100");
  endtask

  task automatic t_shift_left;
    step(3'b000, 4'b1011, 1'b1, "R2 preload");
    step(3'b100, 4'b0000, 1'b1, "R5 shl 1011");
    step(3'b100, 4'b0000, 1'b1, "R5 shl 0110");
  endtask

  task automatic t_rotate_left;
    step(3'b000, 4'b1001, 1'b1, "R2 preload");
    step(3'b101, 4'b0000, 1'b1, "R6 rotl 1001");
    step(3'b101, 4'b0000, 1'b1, "R6 rotl 0011");
  endtask

  task automatic t_fill;
    step(3'b000, 4'b0000, 1'b1, "R2 clear");
    step(3'b110, 4'b0000, 1'b1, "R7 code110");
    step(3'b000, 4'b0100, 1'b1, "R2 preload");
    step(3'b111, 4'b0000, 1'b1, "R7 code111");
  endtask

  task automatic t_hold;
    step(3'b000, 4'b1010, 1'b1, "R2 preload");
    for (int f = 0; f < 8; f++) begin
      step(3'(f), 4'b0101, 1'b0, $sformatf("R8 hold code%0d", f));
    end
  endtask

  task automatic t_reset_midrun;
    step(3'b000, 4'b0111, 1'b1, "R2 preload");
    @(negedge clk);
    func = 3'b111; enable = 1'b1; par = 4'b1111;
    #3 reset = 1'b1;
    #1 chk("R1 async clear before edge", q, 4'b0000);
    @(posedge clk); #2 chk("R9 reset beats fill", q, 4'b0000);
    @(posedge clk); #2 chk("R9 reset beats fill again", q, 4'b0000);
    @(negedge clk);
    func = 3'b000; par = 4'b1100;
    reset = 1'b0;
    mdl = 4'b0000;
    @(posedge clk); #2;
    mdl = 4'b1100;
    chk("R9 first edge after release", q, mdl);
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      logic [2:0] f;
      logic [3:0] d;
      logic en;
      f = 3'($urandom_range(0, 7));
      d = 4'($urandom_range(0, 15));
      en = ($urandom_range(0, 3) != 0);
      step(f, d, en, {tagOf(f, en), " random"});
    end
  endtask

  initial begin
    reset = 1'b1; enable = 1'b0; func = 3'b000; par = 4'b0000; mdl = 4'b0000;
    @(posedge clk); #2;
    t_reset_state;
    t_load;
    t_shift_right;
    t_rotate_right;
    t_shift_left;
    t_rotate_left;
    t_fill;
    t_hold;
    t_reset_midrun;
    t_random;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule